// File: doc/BRIEF.md
# Management Data Serial Master

This block runs the serial management link between a MAC and its PHY. Software issues one 32-bit command word. The word carries a PHY address, a register address, a transfer direction and, for a write, a 16-bit payload. The block then clocks a complete management frame out on the MDC line. It drives the data line through a separate output-enable, so an external tri-state pad can release the line when the PHY must answer.

A status word of the same width is always visible. It shows whether a frame is in progress, whether the last frame has finished, the address of the last accepted command, and a 16-bit data field. For a read, that data field is filled with the bits the PHY returned. The MDC half-period is set by a parameter counted in system clocks. The preamble length is also a parameter and defaults to 35 ones.

Software polls the busy and done bits. It issues the next command only once busy is low; a command issued while busy is ignored.

Top module: `mdio_master`

## Requirements
- R1: After reset, mdc is 0, mdio_oe is 0 and every bit of status is 0.
- R2: A cycle with cmd_wr high while idle starts a frame when cmd_wdata bit 27 (read) or bit 26 (write) is set. If both bits are set the frame is a read. If neither is set the command is ignored. Busy (status bit 29) is 1 from the next cycle.
- R3: For every frame bit, mdc is low for HALF_DIV clocks and then high for HALF_DIV clocks. While idle, mdc stays low.
- R4: Every frame opens with PRE_LEN ones, followed by the start pattern 0 then 1.
- R5: After the start pattern come the opcode, then the PHY address from cmd_wdata[25:21], then the register address from cmd_wdata[20:16], both MSB first. The opcode is 0,1 for a write and 1,0 for a read.
- R6: A write continues with the turnaround pattern 1,0 and then cmd_wdata[15:0] MSB first, for PRE_LEN+32 bits in all. mdio_oe stays high for the whole write frame.
- R7: A read releases the line (mdio_oe low) from the turnaround bit through the end of the frame, for PRE_LEN+31 bits in all. For each of the last 16 bits, mdio_i is sampled on the clock that ends the high MDC phase, and the samples are assembled MSB first into status[15:0].
- R8: During a frame, mdio_o and mdio_oe change only on the clock at which mdc falls.
- R9: A command issued while busy has no effect on the frame or on the status word.
- R10: Status bit 28 (done) clears when a command is accepted. Done sets, and busy clears, on the clock after the last high MDC phase. status[25:16] holds the accepted addresses. status[15:0] holds the write payload from the moment a write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word |
| status | output | 32 | Status word: busy, done, address and data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Output enable for the data pad |
| mdio_i | input | 1 | Serial data in from the pad |

## Verification
A bit counter that slips shows up within one MDC period as a wrong level on mdio_o or a misplaced release of mdio_oe. A bit counter that is off by one shows up as a misaligned payload or a wrong frame length, and that length error moves the done edge by a full bit. A divider fault bends the mdc waveform within a single half-period. A sampling fault or a sampling edge that is off by one shows up only when the read completes, as a shifted or corrupted status[15:0]. The reference model is compared against all outputs on every clock, so each of these faults is caught in the cycle where it first reaches a port.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  // command and status bit positions
  localparam int CMD_RD_BIT   = 27;
  localparam int CMD_WR_BIT   = 26;
  localparam int STS_DONE_BIT = 28;
  localparam int STS_BUSY_BIT = 29;

  // fixed frame fields
  localparam logic [1:0] FLD_START = 2'b01;
  localparam logic [1:0] FLD_OP_WR = 2'b01;
  localparam logic [1:0] FLD_OP_RD = 2'b10;
  localparam logic [1:0] FLD_TA_WR = 2'b10;

  typedef struct packed {
    logic        rd;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] data;
  } mdio_cmd_t;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic mdc,
  output logic bit_end
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          hi_q, hi_d;
  logic          wrap;

  assign wrap = (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d   = cnt_q;
    hi_d    = hi_q;
    bit_end = 1'b0;
    if (start) begin
      cnt_d = '0;
      hi_d  = 1'b0;
    end else if (run) begin
      if (wrap) begin
        cnt_d   = '0;
        hi_d    = ~hi_q;
        bit_end = hi_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      cnt_d = '0;
      hi_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hi_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      hi_q  <= hi_d;
    end
  end

  assign mdc = hi_q;

endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 35
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mdio_cmd_t   cmd,
  input  logic        bit_end,
  input  logic        mdio_i,
  output logic        busy,
  output logic        is_rd,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        fin,
  output logic [15:0] rd_word
);
  localparam int HEAD_W  = PRE_LEN + 14;
  localparam int FRAME_W = HEAD_W + 18;
  localparam int RD_LEN  = HEAD_W + 17;
  localparam int IW      = $clog2(FRAME_W + 1);

  logic               busy_q, busy_d;
  logic               rd_q, rd_d;
  logic               out_q, out_d;
  logic               oe_q, oe_d;
  logic [IW-1:0]      idx_q, idx_d;
  logic [IW-1:0]      last_idx;
  logic [FRAME_W-1:0] shf_q, shf_d;
  logic [FRAME_W-1:0] frame;
  logic [15:0]        smp_q, smp_d;

  assign frame = {{PRE_LEN{1'b1}}, FLD_START,
                  (cmd.rd ? FLD_OP_RD : FLD_OP_WR),
                  cmd.phy, cmd.regad, FLD_TA_WR, cmd.data};

  assign last_idx = rd_q ? IW'(RD_LEN - 1) : IW'(FRAME_W - 1);

  always_comb begin
    busy_d = busy_q;
    rd_d   = rd_q;
    out_d  = out_q;
    oe_d   = oe_q;
    idx_d  = idx_q;
    shf_d  = shf_q;
    smp_d  = smp_q;
    fin    = 1'b0;
    if (start) begin
      busy_d = 1'b1;
      rd_d   = cmd.rd;
      idx_d  = '0;
      shf_d  = frame;
      out_d  = frame[FRAME_W-1];
      oe_d   = 1'b1;
      smp_d  = '0;
    end else if (busy_q && bit_end) begin
      if (rd_q && (idx_q > IW'(HEAD_W)))
        smp_d = {smp_q[14:0], mdio_i};
      if (idx_q == last_idx) begin
        busy_d = 1'b0;
        oe_d   = 1'b0;
        out_d  = 1'b0;
        fin    = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
        shf_d = shf_q << 1;
        out_d = shf_q[FRAME_W-2];
        oe_d  = !(rd_q && (idx_d >= IW'(HEAD_W)));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      out_q  <= 1'b0;
      oe_q   <= 1'b0;
      idx_q  <= '0;
      shf_q  <= '0;
      smp_q  <= '0;
    end else begin
      busy_q <= busy_d;
      rd_q   <= rd_d;
      out_q  <= out_d;
      oe_q   <= oe_d;
      idx_q  <= idx_d;
      shf_q  <= shf_d;
      smp_q  <= smp_d;
    end
  end

  assign busy    = busy_q;
  assign is_rd   = rd_q;
  assign mdio_o  = out_q;
  assign mdio_oe = oe_q;
  assign rd_word = smp_d;

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int PRE_LEN  = 35
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] status,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  mdio_cmd_t   cmd;
  logic        accept;
  logic        seq_busy, seq_rd, seq_fin, bit_end;
  logic [15:0] rd_word;
  logic        done_q, done_d;
  logic [9:0]  addr_q, addr_d;
  logic [15:0] data_q, data_d;
  logic        unused_hi;

  assign unused_hi = ^cmd_wdata[31:28];

  assign cmd.rd    = cmd_wdata[CMD_RD_BIT];
  assign cmd.phy   = cmd_wdata[25:21];
  assign cmd.regad = cmd_wdata[20:16];
  assign cmd.data  = cmd_wdata[15:0];

  assign accept = cmd_wr && !seq_busy &&
                  (cmd_wdata[CMD_RD_BIT] || cmd_wdata[CMD_WR_BIT]);

  mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .run     (seq_busy),
    .mdc     (mdc),
    .bit_end (bit_end)
  );

  mdio_seq #(.PRE_LEN(PRE_LEN)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept),
    .cmd     (cmd),
    .bit_end (bit_end),
    .mdio_i  (mdio_i),
    .busy    (seq_busy),
    .is_rd   (seq_rd),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .fin     (seq_fin),
    .rd_word (rd_word)
  );

  always_comb begin
    done_d = done_q;
    addr_d = addr_q;
    data_d = data_q;
    if (accept) begin
      done_d = 1'b0;
      addr_d = {cmd.phy, cmd.regad};
      if (!cmd.rd) data_d = cmd.data;
    end else if (seq_fin) begin
      done_d = 1'b1;
      if (seq_rd) data_d = rd_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      done_q <= done_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign status = {2'b00, seq_busy, done_q, 2'b00, addr_q, data_q};

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_wr,
  input logic [31:0] status,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        is_rd
);
  logic busy;
  assign busy = status[29];

  // R2
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_wr));

  // R3
  idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  // R6
  write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !is_rd) |-> mdio_oe);

  // R8
  line_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$fell(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(status[25:16]));

  // R10
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !status[28]);

endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cmd_wr  (cmd_wr),
  .status  (status),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe),
  .is_rd   (seq_rd)
);

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;
  localparam int H    = 2;
  localparam int PRE  = 35;
  localparam int HEAD = PRE + 14;

  logic        clk, rst_n, cmd_wr, mdio_i;
  logic [31:0] cmd_wdata, status;
  logic        mdc, mdio_o, mdio_oe;

  int checks, fails, cycles;

  // reference model state
  bit          m_bits[$];
  int          m_busy, m_t, m_n, m_rd, m_done;
  logic [9:0]  m_addr;
  logic [15:0] m_data, m_smp, resp;

  mdio_master #(.HALF_DIV(H), .PRE_LEN(PRE)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .status(status), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // model: advance on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_t = 0; m_n = 0; m_rd = 0; m_done = 0;
      m_addr = '0; m_data = '0; m_smp = '0;
    end else if (m_busy != 0) begin
      m_t = m_t + 1;
      if (m_t % (2*H) == 0) begin
        if (m_rd != 0 && (m_t/(2*H) - 1) > HEAD) m_smp = {m_smp[14:0], mdio_i};
        if (m_t == 2*H*m_n) begin
          m_busy = 0; m_done = 1;
          if (m_rd != 0) m_data = m_smp;
        end
      end
    end else if (cmd_wr && (cmd_wdata[27] || cmd_wdata[26])) begin
      m_busy = 1; m_t = 0; m_done = 0; m_smp = '0;
      m_rd   = cmd_wdata[27] ? 1 : 0;
      m_addr = cmd_wdata[25:16];
      m_bits.delete();
      for (int i = 0; i < PRE; i++) m_bits.push_back(1'b1);
      m_bits.push_back(1'b0); m_bits.push_back(1'b1);
      if (m_rd != 0) begin m_bits.push_back(1'b1); m_bits.push_back(1'b0); end
      else begin m_bits.push_back(1'b0); m_bits.push_back(1'b1); end
      for (int i = 25; i >= 16; i--) m_bits.push_back(cmd_wdata[i]);
      if (m_rd == 0) begin
        m_bits.push_back(1'b1); m_bits.push_back(1'b0);
        for (int i = 15; i >= 0; i--) m_bits.push_back(cmd_wdata[i]);
        m_data = cmd_wdata[15:0];
        m_n = HEAD + 18;
      end else begin
        m_n = HEAD + 17;
      end
    end
  end

  // compare every clock and drive the PHY side on falling edges
  always @(negedge clk) begin
    int k, eoe, emdc;
    string tg;
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected < 150000 cycles", cycles);
      summary();
    end
    if (rst_n) begin
      k    = m_t / (2*H);
      emdc = (m_busy != 0 && (m_t % (2*H)) >= H) ? 1 : 0;
      eoe  = (m_busy != 0 && k < ((m_rd != 0) ? HEAD : m_n)) ? 1 : 0;
      check(32'(mdc), 32'(emdc), "R3 mdc");
      check(32'(mdio_oe), 32'(eoe), (m_rd != 0) ? "R7 oe" : "R6 oe");
      if (eoe != 0) begin
        if (k < PRE + 2) tg = "R4 mdio_o";
        else if (k < HEAD) tg = "R5 mdio_o";
        else tg = "R6 mdio_o";
        check(32'(mdio_o), 32'(m_bits[k]), tg);
      end
      check(status, {2'b00, m_busy[0], m_done[0], 2'b00, m_addr, m_data}, "R10 status");
      if (m_busy != 0 && m_rd != 0 && k > HEAD && k <= HEAD + 16)
        mdio_i = resp[15 - (k - HEAD - 1)];
      else
        mdio_i = ~mdio_i;
    end
  end

  task automatic issue(input logic [31:0] w);
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = w;
    @(negedge clk); cmd_wr = 1'b0; cmd_wdata = '0;
  endtask

  task automatic wait_idle();
    while (m_busy != 0) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] mk(input bit rd, input bit wr,
                                     input logic [4:0] p, input logic [4:0] r,
                                     input logic [15:0] d);
    return {4'h0, rd, wr, p, r, d};
  endfunction

  initial begin
    checks = 0; fails = 0; cycles = 0;
    rst_n = 1'b0; cmd_wr = 1'b0; cmd_wdata = '0; mdio_i = 1'b0; resp = '0;
    #1;
    // R1: values while reset is held
    check(32'(mdc), 0, "R1 mdc");
    check(32'(mdio_oe), 0, "R1 oe");
    check(status, 0, "R1 status");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(status, 0, "R1 status after release");

    // R2, R4, R5, R6: plain write
    issue(mk(0, 1, 5'h11, 5'h0A, 16'hA5C3));
    check(32'(status[29]), 1, "R2 busy after accept");
    wait_idle();
    check(status, {2'b00, 1'b0, 1'b1, 2'b00, 5'h11, 5'h0A, 16'hA5C3}, "R10 write done");

    // R7: read with distinctive pattern
    resp = 16'h1234;
    issue(mk(1, 0, 5'h01, 5'h03, 16'h0000));
    wait_idle();
    check(32'(status[15:0]), 32'h1234, "R7 read data");
    check(32'(status[28]), 1, "R10 done after read");

    // R7: MSB and LSB boundary
    resp = 16'h8001;
    issue(mk(1, 0, 5'h1F, 5'h00, 16'hFFFF));
    wait_idle();
    check(32'(status[15:0]), 32'h8001, "R7 read edges");

    // R2: both flags make a read
    resp = 16'hBEEF;
    issue(mk(1, 1, 5'h05, 5'h1F, 16'h0F0F));
    wait_idle();
    check(32'(status[15:0]), 32'hBEEF, "R2 both flags read");

    // R2: no flag is ignored
    issue(mk(0, 0, 5'h0C, 5'h0C, 16'h5555));
    check(32'(status[29]), 0, "R2 no flag ignored");
    check(32'(status[25:0]), {5'h05, 5'h1F, 16'hBEEF}, "R2 no flag status");

    // R9: command during a frame ignored
    issue(mk(0, 1, 5'h00, 5'h1F, 16'h0000));
    repeat (40) @(negedge clk);
    issue(mk(1, 0, 5'h1A, 5'h15, 16'h7777));
    check(32'(status[25:16]), {5'h00, 5'h1F}, "R9 busy command ignored");
    wait_idle();
    check(32'(status[15:0]), 32'h0000, "R9 payload kept");

    // R10: back-to-back command right after done
    while (m_busy != 0) @(negedge clk);
    issue(mk(0, 1, 5'h15, 5'h0A, 16'hFFFF));
    check(32'(status[28]), 0, "R10 done cleared on accept");
    wait_idle();
    check(32'(status[15:0]), 32'hFFFF, "R6 all-ones payload");

    repeat (5) @(negedge clk);
    summary();
  end

endmodule